// File: doc/BRIEF.md
# Stream Sync Event Catcher

This block turns an external event pulse into a sync flag on the user sideband of a valid/ready stream. The event can be as short as one clock, and accepted beats can be many cycles apart, for example when only one or two data channels feed the stream. A flag that simply followed the pulse would then miss every beat. The block therefore latches the rising edge of the event in a sticky flag. The flag stays up until a beat with both valid and ready high carries it downstream, and the consumer samples the flag on that same beat.

A parameter chooses how the event input is treated. In one setting the event is taken as already synchronous to the stream clock. In the other it first passes through a flip-flop synchronizer chain. The chain length is a parameter whose default of two adds two cycles of latency. Edge detection compares the event with a registered copy of itself, so a long event pulse is reported only once. In a typical integration ready is tied high, and the flag then clears on every valid beat.

Top module: `sse_catcher`

## Requirements
- R1: While `rst_n` is low, `sync_out` is 0. Reset also clears the edge history, so an event that is already high when reset is released counts as a rising edge at the first clock edge after release.
- R2: With `ASYNC_EVENT` = 0, a clock edge at which `event_in` is 1 after being 0 at the previous edge sets `sync_out` to 1 directly after that edge.
- R3: A clock edge at which `sync_out`, `s_valid` and `s_ready` are all 1, with no new event edge, clears `sync_out` to 0.
- R4: While set, `sync_out` stays 1 through every edge without a handshake, including edges with `s_valid`=1 and `s_ready`=0 and edges with `s_valid`=0 and `s_ready`=1.
- R5: When a new event edge falls on the same clock edge as a clearing handshake, `sync_out` stays 1.
- R6: An event held high for many cycles produces exactly one flag. After that flag is consumed, `sync_out` stays 0 until the event falls and rises again.
- R7: With `ASYNC_EVENT` = 1 and `SYNC_STAGES` = 2, the event passes through two flip-flops before edge detection, so `sync_out` rises two cycles later than with `ASYNC_EVENT` = 0. The hold and clear rules apply unchanged.
- R8: A one-cycle event pulse that falls between two widely spaced beats is not lost. It is carried by the next accepted beat.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Stream clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| s_valid | input | 1 | Stream beat valid |
| s_ready | input | 1 | Stream beat ready |
| event_in | input | 1 | External event, active high |
| sync_out | output | 1 | Sticky sync flag for the stream user sideband |

## Verification
The flag can be set by a new event edge and consumed by a handshake in the same clock cycle. The bench provokes this collision in two ways: directly, by raising the event while a pending flag is being accepted, and through random traffic in which event pulses and beats overlap often. A collision is judged correct when the flag survives that edge; a lone handshake must instead clear it. Both the synchronous and the resynchronized variants run on the same stimulus, and each is compared every cycle with a bench model.

// File: rtl/sse_pkg.sv
package sse_pkg;

   // result of comparing the event level with its registered copy
   typedef struct packed {
      logic rise;
      logic level;
   } sse_edge_t;

   localparam int SSE_MIN_STAGES = 2;
   localparam int SSE_MAX_STAGES = 4;

   function automatic logic sse_next_flag(input logic cur,
                                          input logic set_i,
                                          input logic consume_i);
      return set_i | (cur & ~consume_i);
   endfunction

endpackage

// File: rtl/sse_event_sync.sv
module sse_event_sync #(
   parameter int ASYNC_EVENT = 0,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ev_raw,
   output logic ev_out
);
   import sse_pkg::*;

   if (ASYNC_EVENT != 0 && ASYNC_EVENT != 1)
      $error("sse_event_sync: ASYNC_EVENT must be 0 or 1");
   if (SYNC_STAGES < SSE_MIN_STAGES || SYNC_STAGES > SSE_MAX_STAGES)
      $error("sse_event_sync: SYNC_STAGES out of range");

   if (ASYNC_EVENT == 1) begin : g_resync
      logic [SYNC_STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '0;
         else        chain <= {chain[SYNC_STAGES-2:0], ev_raw};
      end
      assign ev_out = chain[SYNC_STAGES-1];
   end else begin : g_direct
      assign ev_out = ev_raw;
   end

endmodule

// File: rtl/sse_edge_detect.sv
module sse_edge_detect (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              level_in,
   output sse_pkg::sse_edge_t ev_edge
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= level_in;
   end

   assign ev_edge.rise  = level_in & ~prev_q;
   assign ev_edge.level = level_in;

endmodule

// File: rtl/sse_sticky_flag.sv
module sse_sticky_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic consume_i,
   output logic flag_o
);
   import sse_pkg::*;

   logic flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= sse_next_flag(flag_q, set_i, consume_i);
   end

   assign flag_o = flag_q;

endmodule

// File: rtl/sse_catcher.sv
module sse_catcher #(
   parameter int ASYNC_EVENT = 0,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic s_valid,
   input  logic s_ready,
   input  logic event_in,
   output logic sync_out
);
   import sse_pkg::*;

   logic      ev_sync;
   sse_edge_t ev_info;
   logic      beat;

   assign beat = s_valid & s_ready;

   sse_event_sync #(
      .ASYNC_EVENT (ASYNC_EVENT),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .ev_raw (event_in),
      .ev_out (ev_sync)
   );

   sse_edge_detect u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .level_in (ev_sync),
      .ev_edge  (ev_info)
   );

   sse_sticky_flag u_flag (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (ev_info.rise),
      .consume_i (beat),
      .flag_o    (sync_out)
   );

endmodule

// File: rtl/sse_catcher_chk.sv
module sse_catcher_chk #(
   parameter int ASYNC_EVENT = 0,
   parameter int SYNC_STAGES = 2
) (
   input logic clk,
   input logic rst_n,
   input logic s_valid,
   input logic s_ready,
   input logic event_in,
   input logic ev_sync,
   input logic sync_out
);
   // independent view of the detected event edge
   logic ev_seen;
   logic [1:0] since_rst;
   logic new_edge;
   logic hs;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ev_seen   <= 1'b0;
         since_rst <= 2'd0;
      end else begin
         ev_seen <= ev_sync;
         if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
      end
   end

   assign new_edge = ev_sync && !ev_seen;
   assign hs       = s_valid && s_ready;

   always @(posedge clk) begin
      if (!rst_n) a_r1_reset_low: assert (sync_out == 1'b0);
   end

   a_r2_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (new_edge && !hs) |=> sync_out);

   a_r3_beat_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_out && hs && !new_edge) |=> !sync_out);

   a_r4_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_out && !hs) |=> sync_out);

   a_r5_collision_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (new_edge && hs) |=> sync_out);

   a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      (!sync_out && !new_edge) |=> !sync_out);

   if (ASYNC_EVENT == 1 && SYNC_STAGES == 2) begin : g_lat
      a_r7_two_cycle_delay: assert property (@(posedge clk) disable iff (!rst_n)
         (since_rst >= 2'd2) |-> (ev_sync == $past(event_in, 2)));
   end

endmodule

bind sse_catcher sse_catcher_chk #(
   .ASYNC_EVENT (ASYNC_EVENT),
   .SYNC_STAGES (SYNC_STAGES)
) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .s_valid  (s_valid),
   .s_ready  (s_ready),
   .event_in (event_in),
   .ev_sync  (ev_sync),
   .sync_out (sync_out)
);

// File: tb/sse_catcher_tb.sv
module sse_catcher_tb_top;

   logic clk = 1'b0;
   logic rst_n = 1'b1;
   logic s_valid = 1'b0;
   logic s_ready = 1'b0;
   logic event_in = 1'b0;
   logic sync_d, sync_a;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   // reference model state
   logic m_flag, m_prev;
   logic a_flag, a_prev, a_s1, a_s2;

   always #2 clk = ~clk;

   sse_catcher #(.ASYNC_EVENT(0), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
      .event_in(event_in), .sync_out(sync_d));

   sse_catcher #(.ASYNC_EVENT(1), .SYNC_STAGES(2)) dut_async_i (
      .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
      .event_in(event_in), .sync_out(sync_a));

   function automatic logic next_flag(logic cur, logic rise, logic hs);
      return rise | (cur & ~hs);
   endfunction

   task automatic model_reset();
      m_flag = 0; m_prev = 0;
      a_flag = 0; a_prev = 0; a_s1 = 0; a_s2 = 0;
   endtask

   task automatic check(string tag, logic act, logic exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s at %0t: actual %0b expected %0b", tag, $time, act, exp);
      end
   endtask

   // called just after a falling edge: drive, advance model, compare at next falling edge
   task automatic drive(logic v, logic r, logic e, string tag);
      logic hs;
      s_valid = v; s_ready = r; event_in = e;
      hs = v & r;
      m_flag = next_flag(m_flag, e & ~m_prev, hs);
      m_prev = e;
      a_flag = next_flag(a_flag, a_s2 & ~a_prev, hs);
      a_prev = a_s2; a_s2 = a_s1; a_s1 = e;
      @(posedge clk);
      @(negedge clk);
      check(tag, sync_d, m_flag);
      check({tag, " R7"}, sync_a, a_flag);
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      int unused_seed;
      unused_seed = $urandom(32'd20250);
      model_reset();
      #1 rst_n = 1'b0;
      event_in = 1'b1;           // held high across reset release (R1)
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         check("R1 reset", sync_d, 1'b0);
         check("R1 reset R7", sync_a, 1'b0);
      end
      rst_n = 1'b1;
      // R1: event already high gives one edge after release
      drive(0, 0, 1, "R1 release");
      check("R1 set after release", sync_d, 1'b1);
      for (int i = 0; i < 4; i++) drive(0, 0, 1, "R1 wait");
      drive(1, 1, 0, "R3 consume");
      check("R3 cleared", sync_d, 1'b0);
      drive(1, 1, 0, "R3 clear async");

      // R2 / R8: single-cycle pulse, sparse beats
      drive(0, 0, 1, "R2 pulse");
      check("R2 set", sync_d, 1'b1);
      for (int i = 0; i < 8; i++) drive(0, 0, 0, "R8 gap");
      // R4: half handshakes do not clear
      for (int i = 0; i < 3; i++) drive(1, 0, 0, "R4 valid only");
      for (int i = 0; i < 3; i++) drive(0, 1, 0, "R4 ready only");
      check("R4 still set", sync_d, 1'b1);
      drive(1, 1, 0, "R8 carried");
      check("R8 consumed", sync_d, 1'b0);
      for (int i = 0; i < 4; i++) drive(1, 1, 0, "R3 idle beats");

      // R5: new edge on the consuming beat
      drive(0, 0, 1, "R5 first");
      drive(0, 0, 0, "R5 low");
      drive(1, 1, 1, "R5 collision");
      check("R5 kept", sync_d, 1'b1);
      drive(1, 1, 0, "R5 second consume");
      check("R5 then cleared", sync_d, 1'b0);
      for (int i = 0; i < 4; i++) drive(1, 1, 0, "R5 drain");

      // R6: long pulse gives a single flag
      for (int i = 0; i < 12; i++) drive(1, 1, 1, "R6 long");
      check("R6 single", sync_d, 1'b0);
      drive(1, 1, 0, "R6 fall");
      drive(1, 1, 0, "R6 fall");
      drive(1, 1, 0, "R6 fall");

      // random traffic at three beat densities, R2..R8 under collisions
      for (int d = 0; d < 3; d++) begin
         for (int i = 0; i < 3000; i++) begin
            logic v, r, e;
            v = ($urandom % 8) < (d * 3 + 1);
            r = ($urandom % 4) != 0;
            e = ($urandom % 6) == 0;
            drive(v, r, e, "R5 random");
         end
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule